// File: doc/BRIEF.md
# Dual-Channel Disk Controller Configuration Register File

This block holds the type-0 PCI configuration space of a storage function that serves two disk channels. A configuration agent reaches it through a plain access port. Each access carries a dword index, four byte enables, write data and a write strobe. The port returns the addressed dword combinationally on the read data bus. Writes land at the clock edge, one byte lane at a time. Only the bits that each register declares writable can change.

Two rules apply when a dword is read back. While the low nibble of the programming-interface byte reads 0xA, both channels are in compatibility (legacy) mode. In that mode the four channel base address registers read as zero, whatever they hold. The bus-master base register returns a fixed I/O base of 0xCC00 while it still holds only its I/O indicator.

The interrupt level of each channel is passed straight through to a legacy interrupt output. The level is also recorded, one clock later, in bit 7 of a per-channel status byte. Every write that covers the programming-interface byte raises a one-cycle pulse. A per-channel native-mode flag follows that byte.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset, dword 0x00 reads 0x0A111D5A (device 0x0A11, vendor 0x1D5A) and dword 0x04 reads 0x02800081 (status: fast back-to-back bit 7, medium select timing bits 10:9 = 01; command: I/O enable bit 0, wait control bit 7). Dword 0x08 reads 0x01018A06 (class 0x01, subclass 0x01, programming interface 0x8A, revision 0x06). Dword 0x34 reads 0xC0, and dword 0xC0 reads 0x00020001 and is read-only.
- R2: Only bits 0 and 2 of the programming-interface byte (bits 8 and 10 of dword 0x08) are writable. chan_native[0] equals bit 0 of that byte and chan_native[1] equals bit 2.
- R3: Dword 0x3C reads 0x0000010E (interrupt line 0x0E, pin 0x01) and ignores all writes.
- R4: While the programming-interface low nibble is 0xA, dwords 0x10 to 0x1C read zero. Otherwise they read their stored value.
- R5: Dword 0x20 reads 0x0000CC01 while its stored value is exactly 0x00000001. Otherwise it reads its stored value.
- R6: The base registers at 0x10 and 0x18 decode 8 bytes, those at 0x14 and 0x1C decode 4 bytes, and the one at 0x20 decodes 16 bytes. Their address bits below the decode size read back as fixed, and bit 0 always reads 1.
- R7: A write changes only the byte lanes whose enable is set (cfg_be[k] covers bits 8k+7:8k).
- R8: Bit 7 of dword 0x70 (channel 0) and of dword 0x78 (channel 1) shows that channel's interrupt input as sampled at the previous clock edge, and writes to that bit are ignored. Bits 6:0 of those dwords are writable and all their other bits read zero.
- R9: legacy_irq_out[n] equals chan_irq_in[n] in the same cycle.
- R10: mode_changed is high for exactly the one cycle after a write edge with cfg_addr = 2 and cfg_be[1] set, and low otherwise.
- R11: Dword indices that hold no register read zero and ignore writes.
- R12: Dwords 0x40 (reset 0x0A090600), 0x44 (0x00C00068), 0x48 (0xA8A8A8A8), 0x4C (0x000000FF), 0x50 (0x07070707), 0x54 (0x00000004), 0x60 (0x00000200) and 0x68 (0x00000200) are fully writable. In the command word only bits 2:0 are writable, and the status word is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe, taken at the rising edge |
| cfg_rdata | output | 32 | Read data for cfg_addr, after filtering |
| chan_irq_in | input | 2 | Interrupt level from each channel |
| legacy_irq_out | output | 2 | Pass-through legacy interrupt per channel |
| chan_native | output | 2 | Native-mode flag per channel |
| mode_changed | output | 1 | One-cycle pulse after a programming-interface write |

## Verification
The hardest state to reach is a base register that is visible only in native mode and holds a value that came from earlier writes. Reaching it needs a mode switch and a BAR write in the right order. Returning to the 0xCC01 default then needs a later all-zero write that makes the stored value exactly the bare I/O indicator. The sweeps write all-ones, then all-zeros, then single byte lanes, to every dword in ascending order. Each pass therefore crosses the mode byte before the BARs, both into native mode and back into legacy mode. All 64 dwords are re-read after every full-width write, so both filter rules are seen in both modes.

// File: rtl/ide_cfg_pkg.sv
// Package: shared constants and per-dword reset/write-mask tables for the
// configuration space. Assumes 64 dwords; unlisted indices are absent.
package ide_cfg_pkg;

    localparam int N_CHAN      = 2;
    localparam int DW_PROGIF   = 2;
    localparam int DW_BAR_FIRST = 4;
    localparam int DW_BAR_LAST  = 7;
    localparam int DW_BMBAR    = 8;
    localparam int DW_IRQ0     = 28;
    localparam int IRQ_STRIDE  = 2;

    // Reset value of each dword index
    function automatic logic [31:0] cfg_rst(int idx, logic [15:0] vid, logic [15:0] did);
        case (idx)
            0:  cfg_rst = {did, vid};
            1:  cfg_rst = 32'h0280_0081;
            2:  cfg_rst = 32'h0101_8A06;
            4, 5, 6, 7, 8: cfg_rst = 32'h0000_0001;
            13: cfg_rst = 32'h0000_00C0;
            15: cfg_rst = 32'h0000_010E;
            16: cfg_rst = 32'h0A09_0600;
            17: cfg_rst = 32'h00C0_0068;
            18: cfg_rst = 32'hA8A8_A8A8;
            19: cfg_rst = 32'h0000_00FF;
            20: cfg_rst = 32'h0707_0707;
            21: cfg_rst = 32'h0000_0004;
            24, 26: cfg_rst = 32'h0000_0200;
            48: cfg_rst = 32'h0002_0001;
            default: cfg_rst = 32'h0;
        endcase
    endfunction

    // Write mask of each dword index (1 = software may change the bit)
    function automatic logic [31:0] cfg_mask(int idx);
        case (idx)
            1:  cfg_mask = 32'h0000_0007;
            2:  cfg_mask = 32'h0000_0500;
            4, 6: cfg_mask = 32'hFFFF_FFF8;
            5, 7: cfg_mask = 32'hFFFF_FFFC;
            8:  cfg_mask = 32'hFFFF_FFF0;
            16, 17, 18, 19, 20, 21, 24, 26: cfg_mask = 32'hFFFF_FFFF;
            28, 30: cfg_mask = 32'h0000_007F;
            default: cfg_mask = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/ide_cfg_regfile.sv
// Module: register storage. Each dword keeps its reset constant in the
// bits outside its write mask; writable bits change per byte lane.
// The per-channel interrupt status bit is hardware owned.
// Assumes a synchronous active-low reset held for at least one edge.
module ide_cfg_regfile
    import ide_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] VENDOR_ID = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID = 16'h0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              wr_en,
    input  logic [N_CHAN-1:0] irq_lvl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_raw,
    output logic [7:0]        progif
);
    localparam int NDW = 1 << ADDR_W;

    logic [31:0]       dw_q [NDW];
    logic [31:0]       lane_m;
    logic [N_CHAN-1:0] irq_q;

    // Expand byte enables into a bit mask
    always_comb lane_m = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};

    for (genvar g = 0; g < NDW; g++) begin : g_dw
        localparam logic [31:0] RV = cfg_rst(g, VENDOR_ID, DEVICE_ID);
        localparam logic [31:0] MK = cfg_mask(g);
        // Masked per-lane update of one dword
        always_ff @(posedge clk) begin
            if (!rst_n)
                dw_q[g] <= RV;
            else if (wr_en && wr_addr == ADDR_W'(g))
                dw_q[g] <= (dw_q[g] & ~(MK & lane_m)) | (wr_data & MK & lane_m);
        end
    end

    // Sample each channel interrupt level for its status bit
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_lvl;
    end

    // Select the addressed dword and overlay the interrupt status bits
    always_comb begin
        rd_raw = dw_q[rd_addr];
        for (int n = 0; n < N_CHAN; n++) begin
            if (int'(rd_addr) == DW_IRQ0 + IRQ_STRIDE * n)
                rd_raw[7] = irq_q[n];
        end
    end

    // Expose the programming-interface byte
    always_comb progif = dw_q[DW_PROGIF][15:8];
endmodule

// File: rtl/ide_cfg_rd_filter.sv
// Module: read-back rules. Hides the channel BARs in legacy mode and
// substitutes the default bus-master I/O base when that BAR is bare.
// Assumes rd_raw already holds the stored dword for rd_addr.
module ide_cfg_rd_filter
    import ide_cfg_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [31:0] BM_DEFAULT = 32'h0000_CC01
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_raw,
    input  logic [7:0]        progif,
    output logic [31:0]       rd_data
);
    logic legacy;
    logic in_bars;

    // Decode legacy mode and the hidden BAR range
    always_comb begin
        legacy  = (progif[3:0] == 4'hA);
        in_bars = (int'(rd_addr) >= DW_BAR_FIRST) && (int'(rd_addr) <= DW_BAR_LAST);
    end

    // Apply the read-back rules
    always_comb begin
        if (legacy && in_bars)
            rd_data = '0;
        else if (int'(rd_addr) == DW_BMBAR && rd_raw == 32'h0000_0001)
            rd_data = BM_DEFAULT;
        else
            rd_data = rd_raw;
    end
endmodule

// File: rtl/ide_cfg_mode.sv
// Module: mode tracking. Pulses after any write covering the
// programming-interface byte and exposes per-channel native flags.
// Assumes channel n's native bit sits at bit 2n of that byte.
module ide_cfg_mode
    import ide_cfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic              wr_en,
    input  logic [7:0]        progif,
    output logic [N_CHAN-1:0] native,
    output logic              changed
);
    // Register the pulse for a write that covers byte 1 of dword 2
    always_ff @(posedge clk) begin
        if (!rst_n) changed <= 1'b0;
        else        changed <= wr_en && wr_addr == ADDR_W'(DW_PROGIF) && wr_be[1];
    end

    for (genvar n = 0; n < N_CHAN; n++) begin : g_nat
        // Pick channel n's native bit
        always_comb native[n] = progif[2*n];
    end
endmodule

// File: rtl/ide_cfg_space.sv
// Module: top of the configuration register file for a two-channel disk
// function. Reads are combinational; writes take effect at the edge.
// Assumes a single access port owned by one configuration agent.
module ide_cfg_space
    import ide_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] VENDOR_ID = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID = 16'h0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_we,
    output logic [31:0]       cfg_rdata,
    input  logic [1:0]        chan_irq_in,
    output logic [1:0]        legacy_irq_out,
    output logic [1:0]        chan_native,
    output logic              mode_changed
);
    logic [31:0] rd_raw;
    logic [7:0]  progif;

    ide_cfg_regfile #(
        .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(cfg_addr), .wr_be(cfg_be), .wr_data(cfg_wdata), .wr_en(cfg_we),
        .irq_lvl(chan_irq_in), .rd_addr(cfg_addr), .rd_raw(rd_raw), .progif(progif)
    );

    ide_cfg_rd_filter #(.ADDR_W(ADDR_W)) u_filt (
        .rd_addr(cfg_addr), .rd_raw(rd_raw), .progif(progif), .rd_data(cfg_rdata)
    );

    ide_cfg_mode #(.ADDR_W(ADDR_W)) u_mode (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(cfg_addr), .wr_be(cfg_be), .wr_en(cfg_we),
        .progif(progif), .native(chan_native), .changed(mode_changed)
    );

    // Forward channel interrupt levels to the legacy outputs
    always_comb legacy_irq_out = chan_irq_in;
endmodule

// File: rtl/ide_cfg_space_chk.sv
// Checker: port-level properties of the configuration register file.
module ide_cfg_space_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic              cfg_we,
    input logic [31:0]       cfg_rdata,
    input logic [1:0]        chan_irq_in,
    input logic [1:0]        chan_native
    ,input logic             mode_changed
);
    logic pif_wr;
    always_comb pif_wr = cfg_we && cfg_addr == ADDR_W'(2) && cfg_be[1];

    p_pulse_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pif_wr |=> mode_changed);
    p_no_pulse_otherwise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pif_wr |=> !mode_changed);
    p_native_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pif_wr |=> $stable(chan_native));
    p_legacy_bars_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_native == 2'b00 && cfg_addr >= ADDR_W'(4) && cfg_addr <= ADDR_W'(7))
        |-> cfg_rdata == 32'h0);
    p_irq_line_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == ADDR_W'(15) |-> cfg_rdata == 32'h0000_010E);
    p_irq0_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_addr == ADDR_W'(28)) |-> cfg_rdata[7] == $past(chan_irq_in[0]));
    p_irq1_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_addr == ADDR_W'(30)) |-> cfg_rdata[7] == $past(chan_irq_in[1]));
    p_hole_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == ADDR_W'(63) |-> cfg_rdata == 32'h0);
endmodule

bind ide_cfg_space ide_cfg_space_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .chan_irq_in(chan_irq_in), .chan_native(chan_native),
    .mode_changed(mode_changed)
);

// File: tb/ide_cfg_space_bench.sv
`timescale 1ns/1ps
module ide_cfg_space_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_rdata;
    logic [1:0]  chan_irq_in = 2'b00;
    logic [1:0]  legacy_irq_out;
    logic [1:0]  chan_native;
    logic        mode_changed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] model [64];
    logic [1:0]  irq_m = 2'b00;

    always #4 clk = ~clk;

    ide_cfg_space u_ide_cfg_space (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
        .chan_irq_in(chan_irq_in), .legacy_irq_out(legacy_irq_out),
        .chan_native(chan_native), .mode_changed(mode_changed)
    );

    // Reset values taken from R1, R3, R5, R6, R12
    function automatic logic [31:0] b_rst(int i);
        case (i)
            0: return 32'h0A11_1D5A;   1: return 32'h0280_0081;
            2: return 32'h0101_8A06;   4, 5, 6, 7, 8: return 32'h1;
            13: return 32'hC0;         15: return 32'h10E;
            16: return 32'h0A09_0600;  17: return 32'h00C0_0068;
            18: return 32'hA8A8_A8A8;  19: return 32'hFF;
            20: return 32'h0707_0707;  21: return 32'h4;
            24, 26: return 32'h200;    48: return 32'h0002_0001;
            default: return 32'h0;
        endcase
    endfunction

    // Writable bits from R2, R6, R8, R12
    function automatic logic [31:0] b_mask(int i);
        case (i)
            1: return 32'h7;           2: return 32'h500;
            4, 6: return ~32'h7;       5, 7: return ~32'h3;
            8: return ~32'hF;
            16, 17, 18, 19, 20, 21, 24, 26: return 32'hFFFF_FFFF;
            28, 30: return 32'h7F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0, 2, 13, 48: return "R1";
            1: return "R12";
            3: return "R11";
            15: return "R3";
            4, 5, 6, 7: return "R4/R6";
            8: return "R5/R6";
            28, 30: return "R8";
            16, 17, 18, 19, 20, 21, 24, 26: return "R12";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(int i);
        logic [31:0] v;
        v = model[i];
        if (i == 28) v[7] = irq_m[0];
        if (i == 30) v[7] = irq_m[1];
        if (i >= 4 && i <= 7 && model[2][11:8] == 4'hA) v = 32'h0;
        if (i == 8 && model[8] == 32'h1) v = 32'h0000_CC01;
        return v;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(int i);
        @(negedge clk);
        cfg_addr = 6'(i);
        #1;
        chk(cfg_rdata, exp_rd(i), tag_of(i));
    endtask

    task automatic verify_all();
        for (int i = 0; i < 64; i++) rd(i);
    endtask

    task automatic wr(int i, logic [3:0] be, logic [31:0] d);
        logic [31:0] lm;
        @(negedge clk);
        cfg_addr = 6'(i); cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        model[i] = (model[i] & ~(b_mask(i) & lm)) | (d & b_mask(i) & lm);
        #1;
        chk({31'b0, mode_changed}, {31'b0, (i == 2 && be[1])}, "R10 pulse");
        chk({30'b0, chan_native}, {30'b0, model[2][10], model[2][8]}, "R2 native");
        @(negedge clk);
        #1;
        chk({31'b0, mode_changed}, 32'h0, "R10 pulse width");
    endtask

    task automatic set_irq(logic [1:0] v);
        @(negedge clk);
        chan_irq_in = v;
        #1;
        chk({30'b0, legacy_irq_out}, {30'b0, v}, "R9 passthrough");
        irq_m = v;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = b_rst(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R3 R4 R5 R11: reset image, legacy filtering, bare default
        verify_all();
        chk({31'b0, mode_changed}, 32'h0, "R10 idle");
        chk({30'b0, chan_native}, 32'h0, "R2 reset native");
        // R8 R9: interrupt mirroring on both channels
        set_irq(2'b01); rd(28); rd(30);
        set_irq(2'b10); rd(28); rd(30);
        set_irq(2'b11); rd(28); rd(30);
        wr(28, 4'hF, 32'h0000_0000); rd(28);
        set_irq(2'b00); rd(28); rd(30);
        // R2 R10: mode byte writes, with and without lane 1
        wr(2, 4'b1101, 32'hFFFF_FFFF); rd(2);
        wr(2, 4'b0010, 32'h0000_0100); rd(2); verify_all();
        wr(2, 4'b0010, 32'h0000_0400); rd(2); verify_all();
        wr(2, 4'b0010, 32'h0000_0000); rd(2);
        // R6 R7 R11 R12: all-ones then all-zeros sweeps
        for (int i = 0; i < 64; i++) begin
            wr(i, 4'hF, 32'hFFFF_FFFF);
            verify_all();
        end
        for (int i = 0; i < 64; i++) begin
            wr(i, 4'hF, 32'h0000_0000);
            verify_all();
        end
        // R7: single-lane writes
        for (int i = 0; i < 64; i++) begin
            for (int l = 0; l < 4; l++) begin
                wr(i, 4'(1 << l), 32'h5AC3_963C ^ (32'(i) * 32'h0101_0101));
                rd(i);
            end
        end
        set_irq(2'b10);
        verify_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule